// File: doc/BRIEF.md
# Configuration Access Router

This block lets a processor reach configuration space through two I/O ports. A full-dword write to the address port loads a configuration pointer. The pointer holds an enable bit, a bus number, a device number, a function number and a dword register index. A later access to the data port is then turned into a configuration read or write at that pointer. The byte enables on the I/O request select which bytes of the dword take part.

Bus 0 devices 0, 1 and 2 are served inside the chip. They go, in that order, to the host bridge and memory controller register port, the graphics port bridge register port and the integrated graphics register port. Only function 0 exists on those devices. Every other target goes out on a downstream hub port as a configuration request, and the I/O request stalls until the hub answers. Any access the block does not claim is flagged as an ordinary I/O cycle for other logic to handle.

Top module: `cfg_access_router`

## Requirements
- R1: After reset, io_ack_o, io_pass_o, hub_req_o and all of dev_req_o are low, and the address register reads back as 0.
- R2: A write to I/O dword 0xCF8 with io_be_i = 4'hF loads the address register. The layout is bit 31 enable, [23:16] bus, [15:11] device, [10:8] function and [7:2] dword index. A read of 0xCF8 returns that value with bits [30:24] and [1:0] forced to 0.
- R3: A write to 0xCF8 with io_be_i other than 4'hF leaves the address register unchanged and completes with io_pass_o high.
- R4: An access to the data window at I/O dword 0xCFC while address bit 31 is 0 completes with io_pass_o high. It raises no dev_req_o bit and no hub_req_o.
- R5: A window access with the enable set, bus 0, device d below 3 and function 0 raises dev_req_o[d] only, in the cycle the request is accepted. The port carries io_we_i, the dword index, io_be_i and io_wdata_i. io_ack_o follows one cycle later. A read returns that device's data and a write returns 0 on io_rdata_o.
- R6: A window access to bus 0, device below 3, with a function other than 0 raises no port request. A read returns 32'hFFFF_FFFF and a write is dropped.
- R7: A window access to any other bus or device holds hub_req_o high, with bus, device, function, index, byte enables, write data and direction stable, until hub_ready_i. io_ack_o follows one cycle after hub_ready_i. A read returns hub_rdata_i.
- R8: io_ack_o is a single-cycle pulse, and no port request is raised during it. A request still held through the ack cycle is taken as a new access in the next cycle.
- R9: An access to any I/O address other than dwords 0xCF8 and 0xCFC completes with io_pass_o high and io_rdata_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_req_i | input | 1 | I/O request, held until io_ack_o |
| io_we_i | input | 1 | 1 = write, 0 = read |
| io_addr_i | input | IO_AW | I/O byte address |
| io_be_i | input | 4 | Byte enables |
| io_wdata_i | input | 32 | Write data |
| io_ack_o | output | 1 | Completion pulse |
| io_pass_o | output | 1 | With io_ack_o: access not claimed, ordinary I/O cycle |
| io_rdata_o | output | 32 | Read data, valid with io_ack_o |
| dev_req_o | output | N_LOCAL | Per-device register access strobe |
| dev_we_o | output | 1 | Register port write |
| dev_idx_o | output | 6 | Register port dword index |
| dev_be_o | output | 4 | Register port byte enables |
| dev_wdata_o | output | 32 | Register port write data |
| dev_rdata_i | input | 32*N_LOCAL | Combinational read data, device i at bits [32i+31:32i] |
| hub_req_o | output | 1 | Forwarded configuration request |
| hub_we_o | output | 1 | Forwarded direction |
| hub_bus_o | output | 8 | Forwarded bus |
| hub_dev_o | output | 5 | Forwarded device |
| hub_func_o | output | 3 | Forwarded function |
| hub_idx_o | output | 6 | Forwarded dword index |
| hub_be_o | output | 4 | Forwarded byte enables |
| hub_wdata_o | output | 32 | Forwarded write data |
| hub_ready_i | input | 1 | Hub completion |
| hub_rdata_i | input | 32 | Hub read data, valid with hub_ready_i |

## Verification
The ack of one access can fall in the same cycle as the next request, because the requester keeps io_req_i high and changes the fields across the ack. The bench provokes this with back-to-back transactions. In the ack cycle it checks that no device strobe or hub request appears, and in the following cycle it checks that the new access is decoded against the address register just written. A hub access whose ready arrives in its very first cycle is also run back-to-back, so hub completion and a new request meet as closely as the protocol allows.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned BE_W   = 4;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned DEV_W  = 5;
  localparam int unsigned FUNC_W = 3;
  localparam int unsigned IDX_W  = 6;
  // writable bits of the address register
  localparam logic [DW-1:0] AREG_MASK = 32'h80FF_FFFC;

  typedef struct packed {
    logic              en;
    logic [BUS_W-1:0]  bus;
    logic [DEV_W-1:0]  dev;
    logic [FUNC_W-1:0] func;
    logic [IDX_W-1:0]  idx;
  } cfg_ptr_t;

  typedef enum logic [2:0] {
    RT_PASS,
    RT_AREG_WR,
    RT_AREG_RD,
    RT_LOCAL,
    RT_ABSENT,
    RT_HUB
  } route_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HUB,
    ST_ACK
  } state_e;
endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
  import cfg_router_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] wdata_i,
  output cfg_ptr_t      ptr_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] areg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     areg_q <= '0;
    else if (load_i) areg_q <= wdata_i & AREG_MASK;
  end

  assign rdata_o    = areg_q;
  assign ptr_o.en   = areg_q[31];
  assign ptr_o.bus  = areg_q[23:16];
  assign ptr_o.dev  = areg_q[15:11];
  assign ptr_o.func = areg_q[10:8];
  assign ptr_o.idx  = areg_q[7:2];
endmodule

// File: rtl/cfg_target_decode.sv
module cfg_target_decode
  import cfg_router_pkg::*;
#(
  parameter int unsigned          IO_AW     = 16,
  parameter logic [IO_AW-1:0]     ADDR_PORT = 16'hCF8,
  parameter logic [IO_AW-1:0]     DATA_PORT = 16'hCFC,
  parameter int unsigned          N_LOCAL   = 3
) (
  input  logic [IO_AW-1:0]   io_addr_i,
  input  logic               io_we_i,
  input  logic [BE_W-1:0]    io_be_i,
  input  cfg_ptr_t           ptr_i,
  output route_e             route_o,
  output logic [N_LOCAL-1:0] local_sel_o
);
  localparam logic [IO_AW-1:0] LANE_BITS = IO_AW'(3);

  logic hit_areg, hit_win, local_dev;

  // dword match, byte lane bits ignored
  assign hit_areg  = (io_addr_i | LANE_BITS) == (ADDR_PORT | LANE_BITS);
  assign hit_win   = (io_addr_i | LANE_BITS) == (DATA_PORT | LANE_BITS);
  assign local_dev = (ptr_i.bus == '0) && (32'(ptr_i.dev) < N_LOCAL);

  always_comb begin
    route_o = RT_PASS;
    if (hit_areg) begin
      if (!io_we_i)               route_o = RT_AREG_RD;
      else if (io_be_i == '1)     route_o = RT_AREG_WR;
    end else if (hit_win && ptr_i.en) begin
      if (!local_dev)             route_o = RT_HUB;
      else if (ptr_i.func == '0)  route_o = RT_LOCAL;
      else                        route_o = RT_ABSENT;
    end
  end

  for (genvar g = 0; g < N_LOCAL; g++) begin : g_sel
    assign local_sel_o[g] = (route_o == RT_LOCAL) && (ptr_i.dev == DEV_W'(g));
  end
endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
  import cfg_router_pkg::*;
#(
  parameter int unsigned      IO_AW     = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'hCF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'hCFC,
  parameter int unsigned      N_LOCAL   = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  io_req_i,
  input  logic                  io_we_i,
  input  logic [IO_AW-1:0]      io_addr_i,
  input  logic [3:0]            io_be_i,
  input  logic [31:0]           io_wdata_i,
  output logic                  io_ack_o,
  output logic                  io_pass_o,
  output logic [31:0]           io_rdata_o,
  output logic [N_LOCAL-1:0]    dev_req_o,
  output logic                  dev_we_o,
  output logic [5:0]            dev_idx_o,
  output logic [3:0]            dev_be_o,
  output logic [31:0]           dev_wdata_o,
  input  logic [32*N_LOCAL-1:0] dev_rdata_i,
  output logic                  hub_req_o,
  output logic                  hub_we_o,
  output logic [7:0]            hub_bus_o,
  output logic [4:0]            hub_dev_o,
  output logic [2:0]            hub_func_o,
  output logic [5:0]            hub_idx_o,
  output logic [3:0]            hub_be_o,
  output logic [31:0]           hub_wdata_o,
  input  logic                  hub_ready_i,
  input  logic [31:0]           hub_rdata_i
);
  state_e             state_q;
  cfg_ptr_t           ptr;
  logic [DW-1:0]      areg_rdata;
  route_e             route;
  logic [N_LOCAL-1:0] local_sel;
  logic [DW-1:0]      local_rdata;
  logic               accept;
  logic [DW-1:0]      rdata_q;
  logic               pass_q;
  cfg_ptr_t           hub_ptr_q;
  logic               hub_we_q;
  logic [BE_W-1:0]    hub_be_q;
  logic [DW-1:0]      hub_wdata_q;

  assign accept = (state_q == ST_IDLE) && io_req_i;

  cfg_addr_reg u_areg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept && (route == RT_AREG_WR)),
    .wdata_i (io_wdata_i),
    .ptr_o   (ptr),
    .rdata_o (areg_rdata)
  );

  cfg_target_decode #(
    .IO_AW     (IO_AW),
    .ADDR_PORT (ADDR_PORT),
    .DATA_PORT (DATA_PORT),
    .N_LOCAL   (N_LOCAL)
  ) u_dec (
    .io_addr_i   (io_addr_i),
    .io_we_i     (io_we_i),
    .io_be_i     (io_be_i),
    .ptr_i       (ptr),
    .route_o     (route),
    .local_sel_o (local_sel)
  );

  always_comb begin
    local_rdata = '0;
    for (int i = 0; i < N_LOCAL; i++)
      if (local_sel[i]) local_rdata = local_rdata | dev_rdata_i[i*DW +: DW];
  end

  // internal register ports: one-cycle strobe on acceptance
  assign dev_req_o   = accept ? local_sel : '0;
  assign dev_we_o    = io_we_i;
  assign dev_idx_o   = ptr.idx;
  assign dev_be_o    = io_be_i;
  assign dev_wdata_o = io_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      rdata_q     <= '0;
      pass_q      <= 1'b0;
      hub_ptr_q   <= '0;
      hub_we_q    <= 1'b0;
      hub_be_q    <= '0;
      hub_wdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (io_req_i) begin
          state_q <= ST_ACK;
          rdata_q <= '0;
          pass_q  <= 1'b0;
          unique case (route)
            RT_AREG_RD: rdata_q <= areg_rdata;
            RT_LOCAL:   if (!io_we_i) rdata_q <= local_rdata;
            RT_ABSENT:  if (!io_we_i) rdata_q <= '1;
            RT_HUB: begin
              state_q     <= ST_HUB;
              hub_ptr_q   <= ptr;
              hub_we_q    <= io_we_i;
              hub_be_q    <= io_be_i;
              hub_wdata_q <= io_wdata_i;
            end
            RT_PASS:    pass_q <= 1'b1;
            default: ;
          endcase
        end
        ST_HUB: if (hub_ready_i) begin
          state_q <= ST_ACK;
          rdata_q <= hub_we_q ? '0 : hub_rdata_i;
        end
        default: begin
          state_q <= ST_IDLE;
          pass_q  <= 1'b0;
        end
      endcase
    end
  end

  assign io_ack_o    = (state_q == ST_ACK);
  assign io_pass_o   = pass_q;
  assign io_rdata_o  = rdata_q;

  assign hub_req_o   = (state_q == ST_HUB);
  assign hub_we_o    = hub_we_q;
  assign hub_bus_o   = hub_ptr_q.bus;
  assign hub_dev_o   = hub_ptr_q.dev;
  assign hub_func_o  = hub_ptr_q.func;
  assign hub_idx_o   = hub_ptr_q.idx;
  assign hub_be_o    = hub_be_q;
  assign hub_wdata_o = hub_wdata_q;

  logic unused_en;
  assign unused_en = hub_ptr_q.en;
endmodule

// File: rtl/cfg_access_router_chk.sv
module cfg_access_router_chk #(
  parameter int unsigned N_LOCAL = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               io_ack_o,
  input logic               io_pass_o,
  input logic [N_LOCAL-1:0] dev_req_o,
  input logic               hub_req_o,
  input logic               hub_ready_i,
  input logic [7:0]         hub_bus_o,
  input logic [5:0]         hub_idx_o,
  input logic [31:0]        hub_wdata_o
);
  assert_dev_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dev_req_o));

  assert_dev_then_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_req_o != '0) |=> io_ack_o);

  assert_hub_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hub_req_o && !hub_ready_i) |=>
      (hub_req_o && $stable(hub_bus_o) && $stable(hub_idx_o) && $stable(hub_wdata_o)));

  assert_hub_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hub_req_o && hub_ready_i) |=> (io_ack_o && !hub_req_o));

  assert_ack_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_ack_o |=> !io_ack_o);

  assert_ack_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_ack_o |-> ((dev_req_o == '0) && !hub_req_o));

  assert_pass_with_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_pass_o |-> io_ack_o);
endmodule

bind cfg_access_router cfg_access_router_chk #(.N_LOCAL(N_LOCAL)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .io_ack_o    (io_ack_o),
  .io_pass_o   (io_pass_o),
  .dev_req_o   (dev_req_o),
  .hub_req_o   (hub_req_o),
  .hub_ready_i (hub_ready_i),
  .hub_bus_o   (hub_bus_o),
  .hub_idx_o   (hub_idx_o),
  .hub_wdata_o (hub_wdata_o)
);

// File: tb/cfg_access_router_tb_top.sv
module cfg_access_router_tb_top;
  localparam int NL = 3;

  logic          clk_i = 0;
  logic          rst_ni = 0;
  logic          io_req_i = 0, io_we_i = 0;
  logic [15:0]   io_addr_i = '0;
  logic [3:0]    io_be_i = '0;
  logic [31:0]   io_wdata_i = '0;
  logic          io_ack_o, io_pass_o;
  logic [31:0]   io_rdata_o;
  logic [NL-1:0] dev_req_o;
  logic          dev_we_o;
  logic [5:0]    dev_idx_o;
  logic [3:0]    dev_be_o;
  logic [31:0]   dev_wdata_o;
  logic [32*NL-1:0] dev_rdata_i;
  logic          hub_req_o, hub_we_o;
  logic [7:0]    hub_bus_o;
  logic [4:0]    hub_dev_o;
  logic [2:0]    hub_func_o;
  logic [5:0]    hub_idx_o;
  logic [3:0]    hub_be_o;
  logic [31:0]   hub_wdata_o;
  logic          hub_ready_i = 0;
  logic [31:0]   hub_rdata_i = '0;

  always #5 clk_i = ~clk_i;

  for (genvar g = 0; g < NL; g++) begin : g_regs
    assign dev_rdata_i[g*32 +: 32] = {8'(8'hC0 + g), 18'd0, dev_idx_o};
  end

  cfg_access_router dut_i (.*);

  int checks = 0, fails = 0;
  logic [31:0] areg_m = '0;
  bit held = 0;

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] hub_pat(logic [21:0] tgt);
    return 32'h5A00_0000 ^ {10'd0, tgt};
  endfunction

  // kinds: 0 pass, 1 areg write, 2 areg read, 3 local, 4 absent, 5 hub
  task automatic txn(bit we, logic [15:0] a, logic [3:0] be, logic [31:0] wd,
                     int lat, bit keep, string rq);
    int kind; int d; logic [31:0] exp_rd; logic [21:0] tgt;
    kind = 0; d = 0; exp_rd = '0;
    tgt = {areg_m[23:16], areg_m[15:11], areg_m[10:8], areg_m[7:2]};
    if (a[15:2] == 14'h33E) kind = we ? ((be == 4'hF) ? 1 : 0) : 2;
    else if (a[15:2] == 14'h33F && areg_m[31]) begin
      d = int'(areg_m[15:11]);
      if (areg_m[23:16] == 0 && d < NL) kind = (areg_m[10:8] == 0) ? 3 : 4;
      else kind = 5;
    end
    if (!we) case (kind)
      2: exp_rd = areg_m;
      3: exp_rd = {8'(8'hC0 + d), 18'd0, areg_m[7:2]};
      4: exp_rd = '1;
      5: exp_rd = hub_pat(tgt);
      default: exp_rd = '0;
    endcase
    io_req_i = 1; io_we_i = we; io_addr_i = a; io_be_i = be; io_wdata_i = wd;
    if (held) begin
      #1 chk(dev_req_o == 0 && !hub_req_o, {rq, " R8 quiet in ack cycle"},
             {28'd0, hub_req_o, dev_req_o}, 0);
      @(posedge clk_i); @(negedge clk_i);
    end
    #1;
    chk(dev_req_o == ((kind == 3) ? NL'(1 << d) : NL'(0)), {rq, " strobe"},
        32'(dev_req_o), (kind == 3) ? 32'(1 << d) : 0);
    if (kind == 3)
      chk(dev_we_o == we && dev_idx_o == areg_m[7:2] && dev_be_o == be && dev_wdata_o == wd,
          {rq, " R5 port fields"}, {dev_we_o, 1'b0, dev_idx_o, dev_be_o, 20'd0}, 0);
    @(posedge clk_i); @(negedge clk_i);
    if (kind == 5) begin
      for (int k = 0; ; k++) begin
        chk(hub_req_o && {hub_bus_o, hub_dev_o, hub_func_o, hub_idx_o} == tgt &&
            hub_we_o == we && hub_be_o == be && hub_wdata_o == wd,
            {rq, " R7 hub request"}, {9'd0, hub_req_o, hub_bus_o, hub_dev_o, hub_func_o, hub_idx_o},
            {10'd1, tgt});
        if (k == lat) begin
          hub_ready_i = 1; hub_rdata_i = hub_pat(tgt);
          @(posedge clk_i); @(negedge clk_i);
          hub_ready_i = 0; hub_rdata_i = '0;
          break;
        end
        @(posedge clk_i); @(negedge clk_i);
      end
    end
    chk(io_ack_o && !hub_req_o, {rq, " ack"}, 32'(io_ack_o), 1);
    chk(io_pass_o == (kind == 0), {rq, " pass flag"}, 32'(io_pass_o), 32'(kind == 0));
    chk(io_rdata_o == exp_rd, {rq, " read data"}, io_rdata_o, exp_rd);
    if (kind == 1) areg_m = wd & 32'h80FF_FFFC;
    if (keep) held = 1;
    else begin
      io_req_i = 0; held = 0;
      @(posedge clk_i); @(negedge clk_i);
      chk(!io_ack_o, {rq, " R8 single ack"}, 32'(io_ack_o), 0);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'd1, 32'd0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1 chk(!io_ack_o && !io_pass_o && !hub_req_o && dev_req_o == 0, "R1 reset outputs",
           {28'd0, io_ack_o, io_pass_o, hub_req_o, |dev_req_o}, 0);
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i);
    txn(0, 16'h0CF8, 4'hF, 0, 0, 0, "R1 areg reset read");
    txn(1, 16'h0CF8, 4'hF, 32'hFFFF_FFFF, 0, 0, "R2 areg load ones");
    txn(0, 16'h0CF8, 4'hF, 0, 0, 0, "R2 areg readback masked");
    txn(1, 16'h0CF8, 4'h3, 32'h8000_0000, 0, 0, "R3 partial areg write");
    txn(0, 16'h0CF8, 4'h1, 0, 0, 0, "R3 areg unchanged");
    txn(1, 16'h0CF8, 4'hF, 32'h0000_0810, 0, 0, "R2 areg disabled ptr");
    txn(0, 16'h0CFC, 4'hF, 0, 0, 0, "R4 window disabled read");
    txn(1, 16'h0CFE, 4'hC, 32'h1234_5678, 0, 0, "R4 window disabled write");
    txn(1, 16'h0CF8, 4'hF, 32'h8000_0010, 0, 0, "R2 ptr dev0");
    txn(0, 16'h0CFC, 4'hF, 0, 0, 0, "R5 dev0 read");
    txn(1, 16'h0CF8, 4'hF, 32'h8000_0824, 0, 0, "R2 ptr dev1");
    txn(1, 16'h0CFC, 4'h6, 32'hCAFE_F00D, 0, 0, "R5 dev1 write");
    txn(1, 16'h0CF8, 4'hF, 32'h8000_10FC, 0, 0, "R2 ptr dev2");
    txn(0, 16'h0CFC, 4'hF, 0, 0, 0, "R5 dev2 read");
    txn(1, 16'h0CF8, 4'hF, 32'h8000_0B08, 0, 0, "R2 ptr dev1 fn3");
    txn(0, 16'h0CFC, 4'hF, 0, 0, 0, "R6 absent function read");
    txn(1, 16'h0CFC, 4'hF, 32'hDEAD_BEEF, 0, 0, "R6 absent function write");
    txn(1, 16'h0CF8, 4'hF, 32'h8001_3A44, 0, 0, "R2 ptr bus1");
    txn(0, 16'h0CFC, 4'hF, 0, 3, 0, "R7 hub read slow");
    txn(1, 16'h0CF8, 4'hF, 32'h8000_1800, 0, 0, "R2 ptr bus0 dev3");
    txn(1, 16'h0CFD, 4'h2, 32'h0000_AB00, 0, 0, "R7 hub write fast");
    txn(0, 16'h0080, 4'h1, 0, 0, 0, "R9 other port read");
    txn(1, 16'h0CF4, 4'hF, 32'h1, 0, 0, "R9 neighbour port write");
    // back-to-back with request held across each ack
    txn(1, 16'h0CF8, 4'hF, 32'h8000_0820, 0, 1, "R8 b2b ptr dev1");
    txn(0, 16'h0CFC, 4'hF, 0, 0, 1, "R8 b2b dev1 read");
    txn(1, 16'h0CF8, 4'hF, 32'h8002_0004, 0, 1, "R8 b2b ptr bus2");
    txn(0, 16'h0CFC, 4'hF, 0, 0, 1, "R8 b2b hub read");
    txn(0, 16'h0CF8, 4'hF, 0, 0, 0, "R8 b2b areg read");
    summary();
    $finish;
  end
endmodule